// File: doc/BRIEF.md
# Variable-Frequency Numerically Controlled Oscillator

This block is a single-channel numerically controlled oscillator running on the reference clock. A 16-bit control word sets the phase step. The block turns the control word into an effective increment with a fold rule: a word at or above half scale is replaced by its 16-bit two's complement. As a result, the output frequency rises up to half the reference rate and then falls back symmetrically. A phase accumulator adds that increment on every reference cycle while the run enable is high. The accumulator's top bit is the square-wave output.

A one-cycle strobe marks each low-to-high transition of the square wave. Downstream logic, such as a constant-frequency pulse generator, can use it as a clock enable. With a power-of-two control word, the wave has an exactly even duty cycle. This is the intended way to feed such a stage; usable words run from 1 up to 32768, which gives half the reference rate.

A small state machine tracks the run enable. It has two states, ST_IDLE and ST_RUN, and two transitions:

- LAUNCH: ST_IDLE to ST_RUN when the run enable is high.
- HALT: ST_RUN to ST_IDLE when the run enable is low.

In ST_IDLE, or whenever the enable is low, the accumulator is cleared. In ST_RUN, it keeps its phase, even when the control word changes.

Top module: `nco_clkgen`

## Requirements
- R1: While rst_n is low, nco_out and tick are both 0.
- R2: After any clock edge at which run is low, the accumulator is zero, so nco_out and tick are 0; changes of ctl_word while run is low have no effect on the outputs.
- R3: The effective increment is ctl_word when ctl_word[15] is 0, and 65536 minus ctl_word otherwise; ctl_word 16'h8000 gives increment 32768, and ctl_word values c and 65536-c give identical output sequences.
- R4: At each clock edge with run high, the 16-bit accumulator gains the increment modulo 65536, and nco_out is accumulator bit 15. Starting from zero, exactly W rising edges occur within 65536 cycles, so the output frequency is W/65536 of the reference.
- R5: With a power-of-two increment 2^k (8 <= k <= 15), nco_out is high for exactly half of every 2^(16-k)-cycle period; with ctl_word 16'h8000 it toggles on every cycle.
- R6: tick is high for exactly the cycles in which nco_out is 1 and was 0 in the previous cycle; it is never high on two consecutive cycles.
- R7: A change of ctl_word while run stays high takes effect at the next accumulation, continuing from the current phase without clearing it.
- R8: With ctl_word 0 and run high, nco_out and tick stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Accumulate enable; low clears the phase |
| ctl_word | input | 16 | Frequency control word |
| nco_out | output | 1 | Variable-frequency square wave (accumulator MSB) |
| tick | output | 1 | One-cycle strobe on each rising edge of nco_out |

## Verification
The bench tracks the phase with its own arithmetic model and compares both outputs on every cycle. It targets the following cases:

- **Fold boundary.** It uses 16'h8000, which must toggle on every cycle, and mirrored word pairs, which must produce the same sequence. A design that folded with a plain bit inversion would be off by one step and drift apart.
- **Power-of-two duty.** It measures the duty cycle for every power-of-two step from 2^8 to 2^15. An accumulator of the wrong width, or a wrong output bit, would show an uneven duty.
- **Full wrap.** It counts rising edges over a complete 65536-cycle wrap, which exposes any dropped carry or off-by-one step.
- **Word change while running.** It changes the control word mid-run. A design that cleared the phase on the change would break the model sequence in the following cycle.
- **Zero word and idle writes.** It checks a zero control word and control-word changes while idle; a design that accumulated while disabled would raise the output.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } nco_state_e;
endpackage

// File: rtl/nco_fold.sv
// Derives the effective phase increment from the control word:
// upper half of the range is mirrored by two's complement.
module nco_fold #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] word_i,
    output logic [ACC_W-1:0] inc_o
);
    localparam int MSB = ACC_W - 1;

    always_comb begin
        if (word_i[MSB]) begin
            inc_o = (~word_i) + {{(ACC_W-1){1'b0}}, 1'b1};
        end else begin
            inc_o = word_i;
        end
    end
endmodule

// File: rtl/nco_phase.sv
// Run-enable state machine and phase accumulator.
module nco_phase
    import nco_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] acc_o
);
    nco_state_e      state_q, state_d;
    logic [ACC_W-1:0] acc_q, acc_d;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // Next-state and datapath process
    always_comb begin
        state_d = state_q;
        acc_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) begin
                    state_d = ST_RUN;          // LAUNCH
                    acc_d   = inc_i;           // phase starts from zero
                end
            end
            ST_RUN: begin
                if (run_i) begin
                    acc_d = acc_q + inc_i;     // keep phase, new step applies
                end else begin
                    state_d = ST_IDLE;         // HALT
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/nco_edge.sv
// Rising-edge strobe on the square-wave output.
module nco_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wave_i,
    output logic tick_o
);
    logic wave_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else begin
            wave_q <= wave_i;
        end
    end

    assign tick_o = wave_i & ~wave_q;
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] ctl_word,
    output logic             nco_out,
    output logic             tick
);
    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] inc_w;
    logic [ACC_W-1:0] acc_q;

    nco_fold #(.ACC_W(ACC_W)) u_fold (
        .word_i (ctl_word),
        .inc_o  (inc_w)
    );

    nco_phase #(.ACC_W(ACC_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .inc_i  (inc_w),
        .acc_o  (acc_q)
    );

    assign nco_out = acc_q[MSB];

    nco_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wave_i (nco_out),
        .tick_o (tick)
    );
endmodule

// File: rtl/nco_clkgen_chk.sv
module nco_clkgen_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [ACC_W-1:0] ctl_word,
    input logic             nco_out,
    input logic             tick,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] inc
);
    localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

    // R1
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!nco_out && !tick);
        end
    end

    a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (acc == '0) && !nco_out && !tick);

    a_r4_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (acc - $past(acc)) == $past(inc));

    a_r5_half_rate_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl_word == HALF && acc[ACC_W-2:0] == '0) |=> nco_out != $past(nco_out));

    a_r6_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (nco_out && !$past(nco_out)));

    a_r6_rise_gives_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nco_out) |-> tick);

    a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r8_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl_word == '0 && acc == '0) |=> acc == '0);
endmodule

bind nco_clkgen nco_clkgen_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ctl_word (ctl_word),
    .nco_out  (nco_out),
    .tick     (tick),
    .acc      (acc_q),
    .inc      (inc_w)
);

// File: tb/tb_nco_clkgen.sv
`timescale 1ns/1ps
module tb_nco_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] ctl_word = 16'h0;
    logic        nco_out, tick;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_acc = 16'h0;
    logic        m_prev = 1'b0;
    logic        seq_a [0:199];

    always #5 clk = ~clk;

    nco_clkgen dut (
        .clk(clk), .rst_n(rst_n), .run(run), .ctl_word(ctl_word),
        .nco_out(nco_out), .tick(tick)
    );

    function automatic logic [15:0] eff_inc(input logic [15:0] c);
        int v;
        v = (c >= 16'h8000) ? (65536 - int'(c)) : int'(c);
        return 16'(v);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One reference cycle: model update at the edge, compare at the falling edge.
    task automatic step(input string req);
        @(posedge clk);
        m_prev = m_acc[15];
        m_acc  = run ? (m_acc + eff_inc(ctl_word)) : 16'h0;
        @(negedge clk);
        check(nco_out == m_acc[15], {req, " out"}, int'(nco_out), int'(m_acc[15]));
        check(tick == (m_acc[15] & ~m_prev), {req, " tick (R6)"}, int'(tick), int'(m_acc[15] & ~m_prev));
    endtask

    task automatic stop_run();
        run = 1'b0;
        step("R2");
        step("R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rises, highs;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(nco_out == 1'b0, "R1 out in reset", int'(nco_out), 0);
        check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
        rst_n = 1'b1;
        step("R1");

        // R2: control word changes while idle have no effect
        ctl_word = 16'h4000;
        for (int i = 0; i < 10; i++) begin
            ctl_word = ctl_word + 16'h0777;
            step("R2 idle");
        end

        // R5: power-of-two duty sweep
        for (int k = 8; k <= 15; k++) begin
            int per;
            per = 65536 >> k;
            ctl_word = 16'(1 << k);
            run = 1'b1;
            highs = 0;
            for (int n = 0; n < 2 * per; n++) begin
                step("R5");
                if (nco_out) highs++;
            end
            check(highs == per, "R5 duty", highs, per);
            stop_run();
        end

        // R5/R3: 16'h8000 toggles every cycle
        ctl_word = 16'h8000;
        run = 1'b1;
        step("R3");
        for (int n = 0; n < 20; n++) begin
            logic prev;
            prev = nco_out;
            step("R3");
            check(nco_out != prev, "R3 half-rate toggle", int'(nco_out), int'(~prev));
        end
        stop_run();

        // R3: mirrored words produce identical sequences
        ctl_word = 16'h1234;
        run = 1'b1;
        for (int n = 0; n < 200; n++) begin
            step("R3");
            seq_a[n] = nco_out;
        end
        stop_run();
        ctl_word = 16'hEDCC;
        run = 1'b1;
        for (int n = 0; n < 200; n++) begin
            step("R3");
            check(nco_out == seq_a[n], "R3 mirror", int'(nco_out), int'(seq_a[n]));
        end
        stop_run();

        // R7: word change mid-run keeps phase
        ctl_word = 16'h0400;
        run = 1'b1;
        for (int n = 0; n < 10; n++) step("R7");
        ctl_word = 16'h0100;
        for (int n = 1; n <= 150; n++) begin
            int ph;
            step("R7");
            ph = (10 * 16'h0400 + n * 16'h0100) % 65536;
            check(nco_out == ph[15], "R7 phase continuity", int'(nco_out), int'(ph[15]));
        end
        // R2: drop run, then idle words ignored
        run = 1'b0;
        step("R2");
        check(nco_out == 1'b0, "R2 stop clears", int'(nco_out), 0);
        ctl_word = 16'h7FFF;
        for (int n = 0; n < 20; n++) begin
            step("R2");
            check(nco_out == 1'b0, "R2 idle out", int'(nco_out), 0);
        end

        // R8: zero word
        ctl_word = 16'h0000;
        run = 1'b1;
        for (int n = 0; n < 50; n++) begin
            step("R8");
            check(nco_out == 1'b0 && tick == 1'b0, "R8 zero word", int'(nco_out), 0);
        end
        stop_run();

        // R4: full wrap edge count
        ctl_word = 16'h0123;
        run = 1'b1;
        rises = 0;
        for (int n = 0; n < 65536; n++) begin
            step("R4");
            if (tick) rises++;
        end
        check(rises == 291, "R4 edges per wrap", rises, 291);
        stop_run();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule